// File: doc/BRIEF.md
# Statistics Counter Update Engine

The engine takes 32-bit count commands over a valid/ready input and applies them to counters held in an on-chip counter RAM. Each command has three fields. A 4-bit opcode sits in bits 31:28, a 12-bit data value in bits 27:16, and a 16-bit index in bits 15:0.

The opcode bits act independently:
- Bit 1 asks for a +1 on a packet counter.
- Bit 0 asks for +data on a byte counter.
- Bit 2 picks the post-queue pair over the pre-queue pair.
- Bit 3 sends the update to the global register region instead of an indexed counter set.

An indexed command whose index is too large for local storage is not applied locally. It is handed, bit for bit, to an external-memory agent over a second valid/ready port. A registered read port lets the counters be inspected.

The RAM holds `RAM_WORDS = SET_BASE + 4*FAST_SETS` words (640 by default):
- Words 0..63 hold global registers.
- Words 64..127 are reserved and are never written.
- Word `128 + 4*i` starts the four-counter set of fast index `i`. The four counters are, in order: pre-queue packets, pre-queue bytes, post-queue packets, post-queue bytes.

The engine handles one command at a time, under control of a state machine:
- IDLE accepts a command and moves to DISPATCH.
- DISPATCH moves to ERROR for a bad opcode, to FORWARD for a slow index, or to READ_A otherwise.
- READ_A moves to UPDATE_A. UPDATE_A moves to READ_B when the command updates a pair, and back to IDLE otherwise.
- READ_B moves to UPDATE_B, and UPDATE_B moves to IDLE.
- FORWARD stays put until the agent takes the request, then moves to IDLE.
- ERROR bumps the error counter and moves to IDLE.

Top module: `stat_update_engine`

## Requirements
- R1: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. After that edge `cmd_ready` stays low until the command has been fully applied, forwarded or rejected.
- R2: Opcode bit 1 adds 1 to the selected packet counter. Opcode bit 0 adds the zero-extended 12-bit data field to the selected byte counter. When both bits are set, both updates happen for the one command.
- R3: For an indexed opcode (bit 3 clear) with index `i` < 128, the packet counter is word `128+4i+2*b2` and the byte counter is the next word, where `b2` is opcode bit 2 (0 = pre-queue, 1 = post-queue).
- R4: For a global opcode (bit 3 set), the target word is `i mod 64`. Under opcode 1011, the +1 goes to word `i mod 64` and the +data goes to word `(i+1) mod 64`.
- R5: An indexed valid opcode with index >= 128 changes no local counter. The full command word appears unchanged on `slow_cmd` with `slow_valid` high, in the order the commands were accepted.
- R6: While `slow_valid` is high and `slow_ready` is low, `slow_cmd` holds steady and `cmd_ready` stays low.
- R7: The valid opcodes are 0001, 0010, 0011, 0101, 0110, 0111, 1001, 1010 and 1011. Any other opcode (0000, 0100, 1000, 1100 to 1111) changes no counter, is not forwarded, and raises `err_count` by exactly 1.
- R8: Counters are `CNT_W` bits wide (32 by default) and wrap modulo 2^`CNT_W`.
- R9: `rd_data` shows the word at the `rd_addr` that was present on the previous clock edge. Addresses at or above 640 read as 0. Reserved words 64..127 stay 0.
- R10: Commands that follow one another back to back on the same word lose no update. Each one builds on the result of the one before.
- R11: After reset, every counter and `err_count` are 0, `cmd_ready` is high and `slow_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_data | input | 32 | Command: opcode[31:28], data[27:16], index[15:0] |
| slow_valid | output | 1 | Slow-counter request offered |
| slow_ready | input | 1 | External agent takes the request |
| slow_cmd | output | 32 | Forwarded command word |
| rd_addr | input | ADDR_W | Inspection read address |
| rd_data | output | CNT_W | Inspection read data, one cycle after the address |
| err_count | output | ERR_W | Count of rejected opcodes |

## Verification
The bench aims at the following corner cases, and each one names the fault it would expose.
- **Combined global opcode at index 63.** The byte word must wrap to global word 0. A design that does not wrap would corrupt reserved word 64 instead.
- **Unlisted opcodes such as 0100, 1000 and 1100.** A design that decodes the bits loosely would touch a counter or forward the command instead of counting an error.
- **Back-to-back updates to one word, and paired updates.** These catch a stale read-modify-write, which would show up as lost increments.
- **Slow-port stall and counter wrap.** A stall exposes any change on the held request or any acceptance of new input while stalled. A narrow counter run past 2^CNT_W exposes any saturation or widening.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int CMD_W   = 32;
    localparam int OP_W    = 4;
    localparam int DATA_W  = 12;
    localparam int INDEX_W = 16;

    typedef enum logic [1:0] {
        CLS_LOCAL = 2'd0,
        CLS_SLOW  = 2'd1,
        CLS_BAD   = 2'd2
    } cmd_class_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DISPATCH = 3'd1,
        ST_READ_A   = 3'd2,
        ST_UPDATE_A = 3'd3,
        ST_READ_B   = 3'd4,
        ST_UPDATE_B = 3'd5,
        ST_FORWARD  = 3'd6,
        ST_ERROR    = 3'd7
    } eng_state_e;
endpackage

// File: rtl/stat_cmd_decode.sv
module stat_cmd_decode
    import stat_pkg::*;
#(
    parameter int CNT_W        = 32,
    parameter int GLOBAL_WORDS = 64,
    parameter int SET_BASE     = 128,
    parameter int FAST_SETS    = 128,
    parameter int ADDR_W       = 10
) (
    input  logic [CMD_W-1:0]  cmd,
    output cmd_class_e        cls,
    output logic              pair,
    output logic [ADDR_W-1:0] addr_a,
    output logic [ADDR_W-1:0] addr_b,
    output logic [CNT_W-1:0]  amt_a,
    output logic [CNT_W-1:0]  amt_b
);
    localparam int GLB_W  = $clog2(GLOBAL_WORDS);
    localparam int FIDX_W = $clog2(FAST_SETS);

    logic [OP_W-1:0]    op;
    logic [DATA_W-1:0]  data;
    logic [INDEX_W-1:0] idx;
    logic               op_ok;
    logic [GLB_W-1:0]   g_pkt, g_byte;
    logic [ADDR_W-1:0]  pkt_word, byte_word;

    assign op   = cmd[CMD_W-1 -: OP_W];
    assign data = cmd[INDEX_W +: DATA_W];
    assign idx  = cmd[INDEX_W-1:0];

    // A valid opcode asks for at least one update and is never 11xx.
    assign op_ok = (op[1] | op[0]) & ~(op[3] & op[2]);

    always_comb begin
        if (!op_ok) begin
            cls = CLS_BAD;
        end else if (op[3]) begin
            cls = CLS_LOCAL;
        end else if (32'(idx) >= FAST_SETS) begin
            cls = CLS_SLOW;
        end else begin
            cls = CLS_LOCAL;
        end
    end

    // Global region: the +data word follows the +1 word only when both are asked.
    assign g_pkt  = idx[GLB_W-1:0];
    assign g_byte = (op[1] & op[0]) ? GLB_W'(g_pkt + 1'b1) : g_pkt;

    always_comb begin
        if (op[3]) begin
            pkt_word  = ADDR_W'(g_pkt);
            byte_word = ADDR_W'(g_byte);
        end else begin
            pkt_word  = ADDR_W'(SET_BASE) + ADDR_W'({idx[FIDX_W-1:0], op[2], 1'b0});
            byte_word = pkt_word + ADDR_W'(1);
        end
    end

    assign pair   = op[1] & op[0];
    assign addr_a = op[1] ? pkt_word : byte_word;
    assign addr_b = byte_word;
    assign amt_a  = op[1] ? CNT_W'(1) : CNT_W'(data);
    assign amt_b  = CNT_W'(data);
endmodule

// File: rtl/stat_counter_ram.sv
module stat_counter_ram #(
    parameter int WORDS  = 640,
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] upd_addr,
    output logic [CNT_W-1:0]  upd_rdata,
    input  logic [ADDR_W-1:0] insp_addr,
    output logic [CNT_W-1:0]  insp_rdata
);
    logic [CNT_W-1:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mem[w] <= '0;
            end
        end else if (we && (32'(waddr) < WORDS)) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_rdata  <= '0;
            insp_rdata <= '0;
        end else begin
            upd_rdata  <= (32'(upd_addr) < WORDS)  ? mem[upd_addr]  : '0;
            insp_rdata <= (32'(insp_addr) < WORDS) ? mem[insp_addr] : '0;
        end
    end
endmodule

// File: rtl/stat_update_engine.sv
module stat_update_engine
    import stat_pkg::*;
#(
    parameter int CNT_W        = 32,
    parameter int ERR_W        = 16,
    parameter int GLOBAL_WORDS = 64,
    parameter int SET_BASE     = 128,
    parameter int FAST_SETS    = 128,
    localparam int RAM_WORDS   = SET_BASE + 4 * FAST_SETS,
    localparam int ADDR_W      = $clog2(RAM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [31:0]       cmd_data,
    output logic              slow_valid,
    input  logic              slow_ready,
    output logic [31:0]       slow_cmd,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic [ERR_W-1:0]  err_count
);
    eng_state_e        state_q, state_d;
    logic [CMD_W-1:0]  cmd_q;
    logic [ERR_W-1:0]  err_q;

    cmd_class_e        cls;
    logic              pair;
    logic [ADDR_W-1:0] addr_a, addr_b;
    logic [CNT_W-1:0]  amt_a, amt_b;

    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr, ram_raddr;
    logic [CNT_W-1:0]  ram_wdata, ram_rdata;
    logic              err_bump;

    stat_cmd_decode #(
        .CNT_W       (CNT_W),
        .GLOBAL_WORDS(GLOBAL_WORDS),
        .SET_BASE    (SET_BASE),
        .FAST_SETS   (FAST_SETS),
        .ADDR_W      (ADDR_W)
    ) u_decode (
        .cmd   (cmd_q),
        .cls   (cls),
        .pair  (pair),
        .addr_a(addr_a),
        .addr_b(addr_b),
        .amt_a (amt_a),
        .amt_b (amt_b)
    );

    stat_counter_ram #(
        .WORDS (RAM_WORDS),
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (ram_we),
        .waddr     (ram_waddr),
        .wdata     (ram_wdata),
        .upd_addr  (ram_raddr),
        .upd_rdata (ram_rdata),
        .insp_addr (rd_addr),
        .insp_rdata(rd_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cmd_valid) state_d = ST_DISPATCH;
            ST_DISPATCH: begin
                unique case (cls)
                    CLS_BAD:  state_d = ST_ERROR;
                    CLS_SLOW: state_d = ST_FORWARD;
                    default:  state_d = ST_READ_A;
                endcase
            end
            ST_READ_A:   state_d = ST_UPDATE_A;
            ST_UPDATE_A: state_d = pair ? ST_READ_B : ST_IDLE;
            ST_READ_B:   state_d = ST_UPDATE_B;
            ST_UPDATE_B: state_d = ST_IDLE;
            ST_FORWARD:  if (slow_ready) state_d = ST_IDLE;
            ST_ERROR:    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            err_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cmd_valid) begin
                cmd_q <= cmd_data;
            end
            if (err_bump) begin
                err_q <= err_q + 1'b1;
            end
        end
    end

    // Outputs per state
    always_comb begin
        cmd_ready = 1'b0;
        slow_valid = 1'b0;
        ram_we    = 1'b0;
        ram_raddr = addr_a;
        ram_waddr = addr_a;
        ram_wdata = ram_rdata + amt_a;
        err_bump  = 1'b0;
        unique case (state_q)
            ST_IDLE:     cmd_ready = 1'b1;
            ST_UPDATE_A: ram_we = 1'b1;
            ST_READ_B:   ram_raddr = addr_b;
            ST_UPDATE_B: begin
                ram_we    = 1'b1;
                ram_waddr = addr_b;
                ram_wdata = ram_rdata + amt_b;
            end
            ST_FORWARD:  slow_valid = 1'b1;
            ST_ERROR:    err_bump = 1'b1;
            default:     ;
        endcase
    end

    assign slow_cmd  = cmd_q;
    assign err_count = err_q;
endmodule

// File: rtl/stat_engine_checker.sv
module stat_engine_checker #(
    parameter int ERR_W     = 16,
    parameter int FAST_SETS = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             slow_valid,
    input logic             slow_ready,
    input logic [31:0]      slow_cmd,
    input logic [ERR_W-1:0] err_count
);
    a_r1_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_valid && !slow_ready) |=> (slow_valid && $stable(slow_cmd)));

    a_r6_input_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        slow_valid |-> !cmd_ready);

    a_r5_slow_only_indexed: assert property (@(posedge clk) disable iff (!rst_n)
        slow_valid |-> (!slow_cmd[31] && (slow_cmd[29:28] != 2'b00)
                        && (32'(slow_cmd[15:0]) >= FAST_SETS)));

    a_r7_err_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count != $past(err_count)) |-> (err_count == ERR_W'($past(err_count) + 1'b1)));
endmodule

bind stat_update_engine stat_engine_checker #(
    .ERR_W    (ERR_W),
    .FAST_SETS(FAST_SETS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .slow_valid(slow_valid),
    .slow_ready(slow_ready),
    .slow_cmd  (slow_cmd),
    .err_count (err_count)
);

// File: tb/stat_update_engine_test.sv
module stat_update_engine_test;
    localparam int CW    = 16;
    localparam int EW    = 16;
    localparam int WORDS = 640;
    localparam int AW    = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [31:0]   cmd_data = '0;
    logic          slow_valid;
    logic          slow_ready = 1'b0;
    logic [31:0]   slow_cmd;
    logic [AW-1:0] rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic [EW-1:0] err_count;

    int checks = 0;
    int errors = 0;
    int slow_mode = 0;  // 0 random, 1 hold low, 2 always high

    logic [CW-1:0] exp_mem [WORDS];
    logic [EW-1:0] exp_err = '0;
    logic [31:0]   sq [2048];
    int sq_wr = 0;
    int sq_rd = 0;

    always #4 clk = ~clk;

    stat_update_engine #(.CNT_W(CW), .ERR_W(EW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .slow_valid(slow_valid), .slow_ready(slow_ready), .slow_cmd(slow_cmd),
        .rd_addr(rd_addr), .rd_data(rd_data), .err_count(err_count)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit op_valid(input logic [3:0] op);
        return op inside {4'b0001, 4'b0010, 4'b0011, 4'b0101, 4'b0110,
                          4'b0111, 4'b1001, 4'b1010, 4'b1011};
    endfunction

    // Reference model of the requirements
    function automatic void model(input logic [31:0] c);
        logic [3:0]  op = c[31:28];
        logic [CW-1:0] d = CW'(c[27:16]);
        int idx = int'(c[15:0]);
        if (!op_valid(op)) begin
            exp_err = exp_err + 1'b1;
        end else if (op[3]) begin
            int g = idx % 64;
            if (op[1]) exp_mem[g] = exp_mem[g] + 1'b1;
            if (op[0]) begin
                int b = op[1] ? (g + 1) % 64 : g;
                exp_mem[b] = exp_mem[b] + d;
            end
        end else if (idx >= 128) begin
            sq[sq_wr % 2048] = c;
            sq_wr++;
        end else begin
            int base = 128 + idx * 4 + (op[2] ? 2 : 0);
            if (op[1]) exp_mem[base] = exp_mem[base] + 1'b1;
            if (op[0]) exp_mem[base + 1] = exp_mem[base + 1] + d;
        end
    endfunction

    task automatic send(input logic [3:0] op, input logic [11:0] d, input logic [15:0] idx);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = {op, d, idx};
        model(cmd_data);
        forever begin
            if (cmd_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic rd_word(input int a, output logic [CW-1:0] v);
        @(negedge clk);
        rd_addr = AW'(a);
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic check_word(input string tag, input int a);
        logic [CW-1:0] v;
        rd_word(a, v);
        check(tag, 32'(v), (a < WORDS) ? 32'(exp_mem[a]) : 32'd0);
    endtask

    // Slow port agent: picks ready, then checks any request taken at the next edge
    initial begin
        forever begin
            @(negedge clk);
            case (slow_mode)
                1: slow_ready = 1'b0;
                2: slow_ready = 1'b1;
                default: slow_ready = ($urandom % 3) != 0;
            endcase
            if (rst_n && slow_valid && slow_ready) begin
                check("R5 forwarded word", slow_cmd, (sq_rd < sq_wr) ? sq[sq_rd % 2048] : 32'hDEAD_BEEF);
                sq_rd++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [CW-1:0] v;
        void'($urandom(32'd7331));
        for (int w = 0; w < WORDS; w++) exp_mem[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 cmd_ready", 32'(cmd_ready), 32'd1);
        check("R11 slow_valid", 32'(slow_valid), 32'd0);
        check("R11 err_count", 32'(err_count), 32'd0);
        check_word("R11 word0", 0);
        check_word("R11 word639", 639);

        // R2/R3 indexed updates
        send(4'b0010, 12'h000, 16'd5); wait_idle();
        check_word("R2 pre pkt +1", 148);
        send(4'b0011, 12'hABC, 16'd5); wait_idle();
        check_word("R2 paired pkt", 148);
        check_word("R2 paired byte", 149);
        send(4'b0110, 12'h000, 16'd127); wait_idle();
        send(4'b0101, 12'h123, 16'd127); wait_idle();
        check_word("R3 post pkt idx127", 638);
        check_word("R3 post byte idx127", 639);
        check_word("R3 pre pkt idx127 untouched", 636);

        // R4 global region
        send(4'b1011, 12'h055, 16'd62); wait_idle();
        check_word("R4 global pkt 62", 62);
        check_word("R4 global byte 63", 63);
        send(4'b1011, 12'h00F, 16'd63); wait_idle();
        check_word("R4 wrap pkt 63", 63);
        check_word("R4 wrap byte to 0", 0);
        check_word("R9 reserved 64", 64);
        send(4'b1001, 12'h321, 16'd70); wait_idle();
        check_word("R4 mod64 add word6", 6);
        send(4'b1010, 12'hFFF, 16'd6); wait_idle();
        check_word("R4 +1 only word6", 6);

        // R7 bad opcodes
        send(4'b0000, 12'hFFF, 16'd5);
        send(4'b0100, 12'hFFF, 16'd5);
        send(4'b1000, 12'hFFF, 16'd5);
        send(4'b1100, 12'hFFF, 16'd5);
        send(4'b1111, 12'hFFF, 16'd200); wait_idle();
        check("R7 err_count", 32'(err_count), 32'(exp_err));
        check_word("R7 word148 unchanged", 148);
        check_word("R7 word149 unchanged", 149);

        // R6 stall on slow port
        slow_mode = 1;
        send(4'b0011, 12'h777, 16'd300);
        repeat (4) @(negedge clk);
        check("R6 slow_valid held", 32'(slow_valid), 32'd1);
        check("R6 slow_cmd held", slow_cmd, {4'b0011, 12'h777, 16'd300});
        check("R6 cmd_ready low", 32'(cmd_ready), 32'd0);
        slow_mode = 2;
        wait_idle();
        check_word("R5 no local change", 128);

        // R10 back to back same word
        send(4'b0001, 12'h010, 16'd9);
        send(4'b0001, 12'h020, 16'd9);
        send(4'b0011, 12'h030, 16'd9);
        wait_idle();
        check_word("R10 same byte word", 165);
        check_word("R10 same pkt word", 164);

        // R8 wrap
        for (int k = 0; k < 17; k++) send(4'b0001, 12'hFFF, 16'd3);
        wait_idle();
        check_word("R8 wrap", 141);
        check("R8 wrap value", 32'(exp_mem[141]), 32'd4079);

        // Random mix
        slow_mode = 0;
        for (int n = 0; n < 400; n++) begin
            logic [15:0] ix;
            case ($urandom % 8)
                0: ix = 16'($urandom % 4);
                1: ix = 16'd62 + 16'($urandom % 2);
                2: ix = 16'd64;
                3: ix = 16'd127;
                4: ix = 16'd128;
                5: ix = 16'($urandom);
                default: ix = 16'($urandom % 128);
            endcase
            send(4'($urandom), 12'($urandom), ix);
            if (($urandom % 4) == 0) repeat ($urandom % 3) @(negedge clk);
        end
        slow_mode = 2;
        wait_idle();
        check("R7 random err_count", 32'(err_count), 32'(exp_err));
        check("R5 all forwarded", 32'(sq_rd), 32'(sq_wr));
        for (int w = 0; w < WORDS; w++) begin
            check_word((w >= 64 && w < 128) ? "R9 reserved sweep" : "R10 sweep", w);
        end
        check_word("R9 out of range", 1000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule